// File: doc/BRIEF.md
# Two-Tier Overcurrent Hiccup Controller

This block decides when a battery pack's discharge switch must open during an overload. Two comparators, outside this block, report whether the current-sense drop is above a lower limit (about 150 mV) or above a higher limit (about 375 mV). Each limit has its own qualification window, counted in clock cycles. The window for the higher limit is much shorter than the window for the lower limit. A flag that stays high for its whole window trips the controller. The discharge switch then opens for a restart period of seventeen lower-tier windows. After that period the switch closes by itself, and qualification starts again from zero.

A sustained fault therefore makes the switch cycle between closed and open. This is hiccup operation. With a lower-tier fault the switch is closed for roughly one cycle in eighteen. With a higher-tier fault the closed share is far smaller. When the fault goes away, the switch stays closed and nothing else has to act.

A two-bit status output shows the controller's phase: idle, qualifying the lower tier, qualifying the higher tier, or holding the switch open. All ports are plain control and status pins. No data stream passes through the block.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: After reset, `dis_off_o` is 0 and `phase_o` is 0 (idle).
- R2: If `lo_trip_i` is sampled high on T1_BLANK consecutive rising edges while the switch is closed, `dis_off_o` goes to 1 right after the last of those edges. It does not go to 1 after fewer than T1_BLANK edges.
- R3: If a tier flag is sampled low before its window completes, that tier's count returns to zero and no trip occurs.
- R4: If `hi_trip_i` is sampled high on T2_BLANK consecutive rising edges while the switch is closed, `dis_off_o` goes to 1 right after the last of those edges.
- R5: The two windows are counted at the same time. Whichever window completes first causes the trip. While both counts are running, `phase_o` reports 2.
- R6: Each trip holds `dis_off_o` at 1 for exactly RESTART_MULT*T1_BLANK cycles (17*T1_BLANK by default). After that, `dis_off_o` returns to 0 on its own.
- R7: While `dis_off_o` is 1, both flags are ignored. This includes the edge on which the switch closes again. After the switch closes, both windows count from zero.
- R8: A fault that persists produces repeated trips. Once both flags stay low, `dis_off_o` stays 0.
- R9: `phase_o` encodes the phase as follows: 0 = idle, 1 = lower-tier window running, 2 = higher-tier window running, 3 = switch held open. The value is 3 exactly when `dis_off_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_trip_i | input | 1 | Sense drop is above the lower overcurrent limit |
| hi_trip_i | input | 1 | Sense drop is above the higher overcurrent limit |
| dis_off_o | output | 1 | Request to open the discharge switch |
| phase_o | output | 2 | Phase code: 0 idle, 1 lower-tier window, 2 higher-tier window, 3 open |

## Verification
The bench builds the block with T1_BLANK = 8, T2_BLANK = 3 and the default multiplier of 17. This gives a restart period of 136 cycles. With these values, complete hiccup cycles for both tiers fit within a few thousand cycles. Random hold lengths of 1 to 12 cycles then fall on both sides of each window limit. This covers near-miss drops, trips in which both tiers are active, and the edge where the switch closes again.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2,
    PH_OPEN = 2'd3
  } phase_e;
endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flag,
  output logic expired,
  output logic running
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // The window completes on the edge that samples the flag for the LIMIT-th time in a row.
  assign expired = flag && (cnt_q == LAST);
  assign running = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (flag)   cnt_q <= cnt_q + 1'b1;
    else             cnt_q <= '0;
  end
endmodule

// File: rtl/ocp_restart_timer.sv
module ocp_restart_timer #(
  parameter int LEN = 136
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN - 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end else if (start) begin
      busy   <= 1'b1;
      left_q <= LOAD;
    end
  end
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
  parameter int T1_BLANK     = 1000,
  parameter int T2_BLANK     = 20,
  parameter int RESTART_MULT = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_trip_i,
  input  logic       hi_trip_i,
  output logic       dis_off_o,
  output logic [1:0] phase_o
);
  import ocp_pkg::*;

  localparam int NTIER   = 2;
  localparam int OFF_LEN = RESTART_MULT * T1_BLANK;
  localparam int LIMITS [NTIER] = '{T1_BLANK, T2_BLANK};

  logic [NTIER-1:0] flags, expired, running;
  logic             busy, trip;

  assign flags = {hi_trip_i, lo_trip_i};

  // A trip is taken only while the switch is closed. Both windows restart on a trip and throughout the open period.
  assign trip = !busy && (|expired);

  for (genvar t = 0; t < NTIER; t++) begin : g_tier
    ocp_blank_timer #(.LIMIT(LIMITS[t])) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (busy | trip),
      .flag    (flags[t]),
      .expired (expired[t]),
      .running (running[t])
    );
  end

  ocp_restart_timer #(.LEN(OFF_LEN)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (trip),
    .busy  (busy)
  );

  phase_e phase;
  always_comb begin
    if (busy)            phase = PH_OPEN;
    else if (running[1]) phase = PH_HI;
    else if (running[0]) phase = PH_LO;
    else                 phase = PH_IDLE;
  end

  assign dis_off_o = busy;
  assign phase_o   = phase;
endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk #(
  parameter int T1_BLANK     = 1000,
  parameter int T2_BLANK     = 20,
  parameter int RESTART_MULT = 17
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lo_trip_i,
  input logic       hi_trip_i,
  input logic       dis_off_o,
  input logic [1:0] phase_o
);
  localparam int OFF_LEN = RESTART_MULT * T1_BLANK;
  localparam int CW = $clog2(OFF_LEN + 2);

  logic [CW-1:0] open_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         open_cnt <= '0;
    else if (dis_off_o) open_cnt <= open_cnt + 1'b1;
    else                open_cnt <= '0;
  end

  a_r9_open_code: assert property (@(posedge clk) disable iff (!rst_n)
    dis_off_o == (phase_o == 2'd3));

  a_r6_open_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dis_off_o) |-> open_cnt == CW'(OFF_LEN));

  a_r7_close_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dis_off_o) |-> phase_o == 2'd0);

  a_r3_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd1 && !lo_trip_i && !hi_trip_i) |=> phase_o == 2'd0);

  a_r2_no_early_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (T1_BLANK > 1 && T2_BLANK > 1 && phase_o == 2'd0) |=> !dis_off_o);
endmodule

bind ocp_hiccup_ctrl ocp_hiccup_chk #(
  .T1_BLANK(T1_BLANK), .T2_BLANK(T2_BLANK), .RESTART_MULT(RESTART_MULT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lo_trip_i(lo_trip_i), .hi_trip_i(hi_trip_i),
  .dis_off_o(dis_off_o), .phase_o(phase_o)
);

// File: tb/ocp_hiccup_ctrl_tb_top.sv
module ocp_hiccup_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T1 = 8;
  localparam int T2 = 3;
  localparam int MULT = 17;
  localparam int OFFN = MULT * T1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo = 1'b0, hi = 1'b0;
  logic dis_off;
  logic [1:0] phase;

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state, derived from the requirements.
  bit m_open = 0;
  int m_left = 0, m_c1 = 0, m_c2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocp_hiccup_ctrl #(.T1_BLANK(T1), .T2_BLANK(T2), .RESTART_MULT(MULT)) dut_i (
    .clk(clk), .rst_n(rst_n), .lo_trip_i(lo), .hi_trip_i(hi),
    .dis_off_o(dis_off), .phase_o(phase)
  );

  function automatic logic [1:0] exp_phase();
    if (m_open)     return 2'd3;
    if (m_c2 != 0)  return 2'd2;
    if (m_c1 != 0)  return 2'd1;
    return 2'd0;
  endfunction

  task automatic model_edge(input bit f1, input bit f2);
    if (m_open) begin
      if (m_left == 0) begin m_open = 0; m_c1 = 0; m_c2 = 0; end
      else m_left--;
    end else if ((f1 && m_c1 == T1-1) || (f2 && m_c2 == T2-1)) begin
      m_open = 1; m_left = OFFN - 1; m_c1 = 0; m_c2 = 0;
    end else begin
      m_c1 = f1 ? m_c1 + 1 : 0;
      m_c2 = f2 ? m_c2 + 1 : 0;
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (dis_off !== m_open || phase !== exp_phase()) begin
      errors++;
      $display("FAIL %s: dis_off=%0b phase=%0d expected dis_off=%0b phase=%0d",
               tag, dis_off, phase, m_open, exp_phase());
    end
  endtask

  // Called at a falling edge: apply the inputs, pass one rising edge, then compare at the falling edge.
  task automatic step(input bit f1, input bit f2, input string tag);
    lo = f1; hi = f2;
    @(posedge clk);
    model_edge(f1, f2);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic expect_true(input bit c, input string tag, input int act, input int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int opens, n;
    bit prev;
    void'($urandom(32'h5eed_0c9));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: the lower tier trips only after its full window.
    for (int i = 0; i < T1-1; i++) step(1, 0, "R2");
    expect_true(dis_off == 0, "R2", dis_off, 0);
    step(1, 0, "R2");
    expect_true(dis_off == 1, "R2", dis_off, 1);

    // R6: length of the open period.
    n = 1;
    while (dis_off) begin step(0, 0, "R6"); if (dis_off) n++; end
    expect_true(n == OFFN, "R6", n, OFFN);

    // R3: near misses never trip.
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < T1-1; i++) step(1, 0, "R3");
      step(0, 0, "R3");
      expect_true(phase == 2'd0, "R3", phase, 0);
    end
    for (int i = 0; i < T2-1; i++) step(0, 1, "R3");
    step(0, 0, "R3");

    // R4: higher-tier trip, then R7: flags ignored while open and on the closing edge.
    for (int i = 0; i < T2; i++) step(0, 1, "R4");
    expect_true(dis_off == 1, "R4", dis_off, 1);
    while (dis_off) step(1, 1, "R7");
    expect_true(phase == 2'd0, "R7", phase, 0);
    step(0, 0, "R7");

    // R5: both tiers running together; the higher tier reports and wins.
    for (int i = 0; i < 4; i++) step(1, 0, "R5");
    step(1, 1, "R5");
    expect_true(phase == 2'd2, "R5", phase, 2);
    for (int i = 0; i < T2-1; i++) step(1, 1, "R5");
    expect_true(dis_off == 1, "R5", dis_off, 1);
    while (dis_off) step(0, 0, "R5");

    // R8: a persistent fault repeats the hiccup; after it clears, the switch stays closed.
    opens = 0; prev = 0;
    for (int i = 0; i < 2*(T1+OFFN)+4; i++) begin
      step(1, 0, "R8");
      if (dis_off && !prev) opens++;
      prev = dis_off;
    end
    expect_true(opens >= 2, "R8", opens, 2);
    while (dis_off) step(0, 0, "R8");
    for (int i = 0; i < 30; i++) step(0, 0, "R8");
    expect_true(dis_off == 0, "R8", dis_off, 0);

    // R9: random hold lengths, all phases compared with the reference.
    for (int s = 0; s < 300; s++) begin
      int len = 1 + int'($urandom_range(11));
      bit f1 = $urandom_range(1);
      bit f2 = ($urandom_range(3) == 0);
      for (int i = 0; i < len; i++) step(f1, f2, "R9");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule